// File: doc/BRIEF.md
# Link Training Sequencer

This block runs the two training phases that bring a serial display link up from the source side: clock recovery, followed by channel equalization, on 1, 2 or 4 active lanes. It issues register reads and writes to the sink through a generic request/done register port and leaves the byte transport to a separate channel controller. Between requests it derives the drive settings for each lane from the adjustment the sink asks for. It then places those settings on per-lane swing, pre-emphasis and post-cursor2 outputs for the transmitter.

A single-cycle start pulse launches a run. The lane count, the pattern-3 capability flag and the sink's read-interval field are all captured at that moment. At the end of every run the sequencer writes the idle pattern. It then raises a one-cycle done pulse, and a pass flag alongside it if training succeeded.

Top module: `lt_seq`

## Requirements
- R1: After start, the first transaction writes pattern value 1 (one byte) to sink address 0x102. Clock recovery then repeats three steps: a 4-byte lane-config write to 0x103, a wait, and a 6-byte status read from 0x202.
- R2: Status byte (i>>1) holds lane i's status nibble, and byte 4+(i>>1) holds its adjust nibble; even lanes use the low nibble. Status nibble bit 0 = CR-done, bit 1 = EQ-done, bit 2 = symbol-locked. Clock recovery passes when every active lane shows CR-done, and lanes at or above the active count are ignored.
- R3: The adjust nibble carries swing in bits 1:0 and pre-emphasis in bits 3:2. Pre-emphasis 3 forces swing to 0 and sets config bit 5. Otherwise a swing of at least 3-minus-pre-emphasis is clamped to that value and sets config bit 2. Config byte = pre-emphasis<<3 | swing | flags. Inactive lanes get 0x00, and swing_o/pre_o carry the clamped 2-bit levels, lane i at bits 2i+1:2i.
- R4: Post-cursor2 status byte 0x20C has lane i's level at bits 2i+1:2i. Level 3 sets flag bit 2, and each lane's nibble is packed low/high into two bytes written to 0x10F. Both this read and this write happen only when pattern 3 is in use. pc2_o carries the raw levels.
- R5: If the lowest failing lane's last committed config has bit 2 set, clock recovery aborts at once.
- R6: The try count restarts whenever lane 0's committed swing differs from its value at the previous check. Clock recovery fails at the fifth check at an unchanged swing.
- R7: Equalization writes pattern 3 if the capability flag is set and pattern 2 otherwise. Its first pass performs no config write.
- R8: Equalization passes when status byte 2 bit 0 (interlane align) is set and every active lane shows all three status bits. It fails when an active lane lacks CR-done, or after the sixth status read.
- R9: The wait before each status read lasts read-interval × 4 × MS_CYC cycles when the read interval is nonzero. Otherwise it lasts CR_WAIT cycles in clock recovery and EQ_WAIT cycles in equalization.
- R10: Every run ends with a write of pattern 0, followed by a one-cycle done_o pulse. pass_o is high in that same cycle only on success, and pattern_o reads 0 there.
- R11: A start pulse while a run is in progress has no effect.
- R12: An error returned on any transaction fails the run, which still ends with the pattern-0 write.
- R13: A request holds its address, direction and length until the cycle in which done is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| lanes_i | input | 3 | Active lane count (1, 2 or 4) |
| tps3_i | input | 1 | Sink accepts pattern 3 |
| rd_intv_i | input | 8 | Sink read-interval field |
| aux_req_o | output | 1 | Transaction request |
| aux_wr_o | output | 1 | 1 = write, 0 = read |
| aux_addr_o | output | 20 | Sink register address |
| aux_len_o | output | 3 | Byte count |
| aux_wdata_o | output | 32 | Write bytes, byte 0 in bits 7:0 |
| aux_rdata_i | input | 48 | Read bytes, byte 0 in bits 7:0 |
| aux_done_i | input | 1 | Transaction complete |
| aux_err_i | input | 1 | Transaction failed, valid with done |
| pattern_o | output | 2 | Active training pattern |
| swing_o | output | 8 | Per-lane swing level |
| pre_o | output | 8 | Per-lane pre-emphasis level |
| pc2_o | output | 8 | Per-lane post-cursor2 level |
| done_o | output | 1 | Run complete pulse |
| pass_o | output | 1 | Run succeeded, with done_o |

## Verification
The bench shrinks the millisecond unit to 20 cycles and sets the two fixed waits to 30 and 60 cycles. With those values the nine-check swing-restart run, the six-pass equalization failure and a nonzero read interval of 160 cycles all complete in a few hundred cycles each. Because the fixed waits differ from each other and from the interval-derived wait, a measured gap shows which wait source was selected. The full default of 200000 cycles per millisecond only matters for the width of the wait counter.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int unsigned NLANE  = 4;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned ST_B   = 6;
  localparam int unsigned CFG_B  = NLANE;
  localparam int unsigned PC2_B  = NLANE / 2;

  localparam logic [ADDR_W-1:0] A_PAT  = 20'h00102;
  localparam logic [ADDR_W-1:0] A_LCFG = 20'h00103;
  localparam logic [ADDR_W-1:0] A_PC2C = 20'h0010F;
  localparam logic [ADDR_W-1:0] A_STAT = 20'h00202;
  localparam logic [ADDR_W-1:0] A_PC2S = 20'h0020C;

  typedef enum logic [3:0] {
    S_IDLE, S_TP, S_CFG, S_PC2W, S_WAIT, S_ST, S_PC2R, S_EVAL, S_FIN
  } lt_state_e;
endpackage

// File: rtl/lt_lane_drv.sv
module lt_lane_drv (
  input  logic [3:0] adj_i,
  input  logic [1:0] pc2_i,
  output logic [7:0] cfg_o,
  output logic [3:0] pc2n_o,
  output logic [1:0] sw_o,
  output logic [1:0] pe_o
);
  logic [1:0] pe, sw, hisw;
  assign pe   = adj_i[3:2];
  assign sw   = adj_i[1:0];
  assign hisw = 2'd3 - pe;

  always_comb begin
    pe_o = pe;
    if (pe == 2'd3) begin
      sw_o  = 2'd0;
      cfg_o = {2'b00, 1'b1, 2'd3, 1'b0, 2'd0};
    end else if (sw >= hisw) begin
      sw_o  = hisw;
      cfg_o = {2'b00, 1'b0, pe, 1'b1, hisw};
    end else begin
      sw_o  = sw;
      cfg_o = {2'b00, 1'b0, pe, 1'b0, sw};
    end
    pc2n_o = (pc2_i == 2'd3) ? 4'b0111 : {2'b00, pc2_i};
  end
endmodule

// File: rtl/lt_wait_tmr.sv
module lt_wait_tmr #(
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == '0);
endmodule

// File: rtl/lt_seq.sv
module lt_seq
  import lt_pkg::*;
#(
  parameter int unsigned MS_CYC  = 200000,
  parameter int unsigned CR_WAIT = 20000,
  parameter int unsigned EQ_WAIT = 80000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        lanes_i,
  input  logic              tps3_i,
  input  logic [7:0]        rd_intv_i,
  output logic              aux_req_o,
  output logic              aux_wr_o,
  output logic [ADDR_W-1:0] aux_addr_o,
  output logic [2:0]        aux_len_o,
  output logic [31:0]       aux_wdata_o,
  input  logic [47:0]       aux_rdata_i,
  input  logic              aux_done_i,
  input  logic              aux_err_i,
  output logic [1:0]        pattern_o,
  output logic [7:0]        swing_o,
  output logic [7:0]        pre_o,
  output logic [7:0]        pc2_o,
  output logic              done_o,
  output logic              pass_o
);
  localparam int unsigned TW = 32;
  localparam logic [2:0] CR_TRIES = 3'd5;
  localparam logic [2:0] EQ_LAST  = 3'd5;

  lt_state_e st_q, st_d;
  logic [2:0] lanes_q, tries_q, try_nx;
  logic       tps3_q, eq_q, ok_q;
  logic [7:0] intv_q;
  logic [1:0] pat_q, last_sw_q;
  logic [ST_B-1:0][7:0]  stat_q;
  logic [7:0]            pc2st_q;
  logic [CFG_B-1:0][7:0] conf_q, conf_n;
  logic [PC2_B-1:0][7:0] pc2c_q, pc2c_n;
  logic [NLANE-1:0][1:0] sw_q, pe_q, pc2_q, sw_n, pe_n, pc2l_n;
  logic [NLANE-1:0] act, crb, eqb, lkb;
  logic go_cfg, go_fail, go_pass, go_eq, tmr_ld, tmr_exp;
  logic cr_all, eq_all, cr_lost, cr_abort, sw_chg;
  logic [TW-1:0] wait_len;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [3:0] st_nib, adj_nib, pc2n;
    logic [7:0] cfg;
    logic [1:0] sw, pe;
    assign st_nib  = stat_q[g/2][(g%2)*4 +: 4];
    assign adj_nib = stat_q[4 + g/2][(g%2)*4 +: 4];
    assign act[g]  = (3'(g) < lanes_q);
    assign crb[g]  = st_nib[0];
    assign eqb[g]  = st_nib[1];
    assign lkb[g]  = st_nib[2];

    lt_lane_drv i_drv (
      .adj_i (adj_nib),
      .pc2_i (pc2st_q[2*g +: 2]),
      .cfg_o (cfg),
      .pc2n_o(pc2n),
      .sw_o  (sw),
      .pe_o  (pe)
    );

    assign conf_n[g]                 = act[g] ? cfg : 8'h00;
    assign pc2c_n[g/2][(g%2)*4 +: 4] = act[g] ? pc2n : 4'h0;
    assign sw_n[g]   = act[g] ? sw : 2'd0;
    assign pe_n[g]   = act[g] ? pe : 2'd0;
    assign pc2l_n[g] = act[g] ? pc2st_q[2*g +: 2] : 2'd0;
  end

  always_comb begin
    cr_abort = 1'b0;
    for (int i = NLANE - 1; i >= 0; i--)
      if (act[i] && !crb[i]) cr_abort = conf_q[i][2];
  end

  assign cr_all  = &(crb | ~act);
  assign cr_lost = |(~crb & act);
  assign eq_all  = stat_q[2][0] && (&((crb & eqb & lkb) | ~act));
  assign sw_chg  = (conf_q[0][1:0] != last_sw_q);
  assign try_nx  = (sw_chg ? 3'd0 : tries_q) + 3'd1;

  assign wait_len = (intv_q != 8'd0) ? TW'(intv_q) * TW'(4 * MS_CYC)
                  : (eq_q ? TW'(EQ_WAIT) : TW'(CR_WAIT));

  lt_wait_tmr #(.TW(TW)) i_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_ld),
    .val_i (wait_len),
    .exp_o (tmr_exp)
  );

  always_comb begin
    st_d = st_q; go_cfg = 1'b0; go_fail = 1'b0; go_pass = 1'b0;
    go_eq = 1'b0; tmr_ld = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) st_d = S_TP;
      S_TP: if (aux_done_i) begin
        if (pat_q == 2'd0)  st_d = S_FIN;
        else if (aux_err_i) go_fail = 1'b1;
        else if (!eq_q)     go_cfg = 1'b1;
        else begin st_d = S_WAIT; tmr_ld = 1'b1; end
      end
      S_CFG: if (aux_done_i) begin
        if (aux_err_i)            go_fail = 1'b1;
        else if (eq_q && tps3_q)  st_d = S_PC2W;
        else begin st_d = S_WAIT; tmr_ld = 1'b1; end
      end
      S_PC2W: if (aux_done_i) begin
        if (aux_err_i) go_fail = 1'b1;
        else begin st_d = S_WAIT; tmr_ld = 1'b1; end
      end
      S_WAIT: if (tmr_exp) st_d = S_ST;
      S_ST: if (aux_done_i) begin
        if (aux_err_i)           go_fail = 1'b1;
        else if (eq_q && tps3_q) st_d = S_PC2R;
        else                     st_d = S_EVAL;
      end
      S_PC2R: if (aux_done_i) begin
        if (aux_err_i) go_fail = 1'b1;
        else           st_d = S_EVAL;
      end
      S_EVAL: if (!eq_q) begin
        if (cr_all)                           go_eq = 1'b1;
        else if (cr_abort || try_nx >= CR_TRIES) go_fail = 1'b1;
        else                                  go_cfg = 1'b1;
      end else begin
        if (eq_all)                           go_pass = 1'b1;
        else if (cr_lost || tries_q == EQ_LAST) go_fail = 1'b1;
        else                                  go_cfg = 1'b1;
      end
      S_FIN: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (go_fail || go_pass || go_eq) st_d = S_TP;
    if (go_cfg) st_d = S_CFG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; lanes_q <= 3'd0; tps3_q <= 1'b0; intv_q <= 8'd0;
      eq_q <= 1'b0; ok_q <= 1'b0; tries_q <= 3'd0; last_sw_q <= 2'd0;
      pat_q <= 2'd0; stat_q <= '0; pc2st_q <= 8'h00;
      conf_q <= '0; pc2c_q <= '0; sw_q <= '0; pe_q <= '0; pc2_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && start_i) begin
        lanes_q <= lanes_i; tps3_q <= tps3_i; intv_q <= rd_intv_i;
        eq_q <= 1'b0; ok_q <= 1'b0; tries_q <= 3'd0; last_sw_q <= 2'd0;
        pat_q <= 2'd1; stat_q <= '0; pc2st_q <= 8'h00; conf_q <= '0;
        pc2c_q <= '0;
      end
      if (st_q == S_ST && aux_done_i && !aux_err_i)   stat_q  <= aux_rdata_i;
      if (st_q == S_PC2R && aux_done_i && !aux_err_i) pc2st_q <= aux_rdata_i[7:0];
      if (go_cfg) begin
        conf_q <= conf_n; pc2c_q <= pc2c_n;
        sw_q <= sw_n; pe_q <= pe_n; pc2_q <= pc2l_n;
        if (st_q == S_EVAL) begin
          if (!eq_q) begin
            tries_q   <= try_nx;
            last_sw_q <= conf_q[0][1:0];
          end else begin
            tries_q <= tries_q + 3'd1;
          end
        end
      end
      if (go_eq) begin
        eq_q <= 1'b1; tries_q <= 3'd0; pat_q <= tps3_q ? 2'd3 : 2'd2;
      end
      if (go_fail) begin pat_q <= 2'd0; ok_q <= 1'b0; end
      if (go_pass) begin pat_q <= 2'd0; ok_q <= 1'b1; end
    end
  end

  always_comb begin
    aux_req_o = 1'b1; aux_wr_o = 1'b0; aux_addr_o = A_STAT;
    aux_len_o = 3'd6; aux_wdata_o = 32'h0;
    unique case (st_q)
      S_TP:   begin aux_wr_o = 1'b1; aux_addr_o = A_PAT;  aux_len_o = 3'd1;
                    aux_wdata_o = {30'h0, pat_q}; end
      S_CFG:  begin aux_wr_o = 1'b1; aux_addr_o = A_LCFG; aux_len_o = 3'(CFG_B);
                    aux_wdata_o = conf_q; end
      S_PC2W: begin aux_wr_o = 1'b1; aux_addr_o = A_PC2C; aux_len_o = 3'(PC2_B);
                    aux_wdata_o = {16'h0, pc2c_q}; end
      S_ST:   ;
      S_PC2R: begin aux_addr_o = A_PC2S; aux_len_o = 3'd1; end
      default: aux_req_o = 1'b0;
    endcase
  end

  assign pattern_o = pat_q;
  assign swing_o   = sw_q;
  assign pre_o     = pe_q;
  assign pc2_o     = pc2_q;
  assign done_o    = (st_q == S_FIN);
  assign pass_o    = (st_q == S_FIN) && ok_q;
endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk
  import lt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              aux_req_o,
  input logic              aux_wr_o,
  input logic [ADDR_W-1:0] aux_addr_o,
  input logic [2:0]        aux_len_o,
  input logic              aux_done_i,
  input logic [1:0]        pattern_o,
  input logic [7:0]        swing_o,
  input logic [7:0]        pre_o,
  input logic              done_o,
  input logic              pass_o
);
  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_req_o && !aux_done_i |=> aux_req_o && $stable(aux_addr_o) &&
                                 $stable(aux_wr_o) && $stable(aux_len_o));
  // R1
  status_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_req_o && !aux_wr_o && aux_addr_o == A_STAT |-> aux_len_o == 3'd6);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  pass_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);
  // R10
  end_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> pattern_o == 2'd0 && !aux_req_o);

  for (genvar g = 0; g < NLANE; g++) begin : g_cap
    // R3
    swing_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ({1'b0, swing_o[2*g +: 2]} + {1'b0, pre_o[2*g +: 2]}) <= 3'd3);
  end
endmodule

bind lt_seq lt_seq_chk i_lt_seq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .aux_req_o (aux_req_o),
  .aux_wr_o  (aux_wr_o),
  .aux_addr_o(aux_addr_o),
  .aux_len_o (aux_len_o),
  .aux_done_i(aux_done_i),
  .pattern_o (pattern_o),
  .swing_o   (swing_o),
  .pre_o     (pre_o),
  .done_o    (done_o),
  .pass_o    (pass_o)
);

// File: tb/test_lt_seq.sv
`timescale 1ns/1ps
module test_lt_seq;
  localparam int MS = 20, CRW = 30, EQW = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, tps3, aux_req, aux_wr, aux_done, aux_err;
  logic        done, pass;
  logic [2:0]  lanes, aux_len;
  logic [7:0]  intv, swing, pre, pc2;
  logic [19:0] aux_addr;
  logic [31:0] aux_wdata;
  logic [47:0] aux_rdata;
  logic [1:0]  pattern;

  lt_seq #(.MS_CYC(MS), .CR_WAIT(CRW), .EQ_WAIT(EQW)) i_lt_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lanes_i(lanes),
    .tps3_i(tps3), .rd_intv_i(intv), .aux_req_o(aux_req), .aux_wr_o(aux_wr),
    .aux_addr_o(aux_addr), .aux_len_o(aux_len), .aux_wdata_o(aux_wdata),
    .aux_rdata_i(aux_rdata), .aux_done_i(aux_done), .aux_err_i(aux_err),
    .pattern_o(pattern), .swing_o(swing), .pre_o(pre), .pc2_o(pc2),
    .done_o(done), .pass_o(pass));

  int n_chk = 0, n_err = 0, cyc = 0;
  logic [47:0] cr_resp [16];
  logic [47:0] eq_resp [16];
  logic [7:0]  pc2_resp, pat_log [4];
  bit   err_st;
  int   n_cr_rd, n_eq_rd, n_cfg_wr, n_pc2_wr, n_pc2_rd, n_tp, cur_pat;
  int   t_last, gap_cr, gap_eq, hold_err, n_done;
  logic [31:0] last_cfg;
  logic [15:0] last_pc2;
  bit   last_pass;
  logic [1:0] pat_at_done;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) begin n_done++; last_pass = pass; pat_at_done = pattern; end
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // sink model
  initial begin
    logic [19:0] a;
    logic [31:0] d;
    logic [47:0] rd;
    logic e;
    int t0;
    aux_done = 1'b0; aux_err = 1'b0; aux_rdata = '0;
    forever begin
      @(negedge clk);
      if (aux_req) begin
        a = aux_addr; d = aux_wdata; rd = '0; e = 1'b0; t0 = cyc;
        case (a)
          20'h00102: begin
            if (n_tp < 4) pat_log[n_tp] = d[7:0];
            n_tp++; cur_pat = int'(d[1:0]);
          end
          20'h00103: begin n_cfg_wr++; last_cfg = d; end
          20'h0010F: begin n_pc2_wr++; last_pc2 = d[15:0]; end
          20'h00202: begin
            e = err_st;
            if (cur_pat == 1) begin
              if (n_cr_rd == 0) gap_cr = t0 - t_last;
              rd = cr_resp[(n_cr_rd > 15) ? 15 : n_cr_rd]; n_cr_rd++;
            end else begin
              if (n_eq_rd == 0) gap_eq = t0 - t_last;
              rd = eq_resp[(n_eq_rd > 15) ? 15 : n_eq_rd]; n_eq_rd++;
            end
          end
          20'h0020C: begin n_pc2_rd++; rd = {40'h0, pc2_resp}; end
          default: ;
        endcase
        @(negedge clk); @(negedge clk);
        if (aux_addr != a || !aux_req) hold_err++;
        aux_done = 1'b1; aux_rdata = rd; aux_err = e;
        @(negedge clk);
        aux_done = 1'b0; aux_err = 1'b0; t_last = cyc;
      end
    end
  end

  task automatic fill(input logic [47:0] cr, input logic [47:0] eq);
    for (int i = 0; i < 16; i++) begin cr_resp[i] = cr; eq_resp[i] = eq; end
  endtask

  task automatic run(input logic [2:0] ln, input bit t3, input logic [7:0] iv,
                     input bit poke);
    int d0;
    n_cr_rd = 0; n_eq_rd = 0; n_cfg_wr = 0; n_pc2_wr = 0; n_pc2_rd = 0;
    n_tp = 0; cur_pat = 0; gap_cr = -1; gap_eq = -1;
    for (int i = 0; i < 4; i++) pat_log[i] = 8'hFF;
    lanes = ln; tps3 = t3; intv = iv;
    d0 = n_done;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 20000 && n_done == d0; k++) begin
      @(negedge clk);
      start = (poke && k == 40);
    end
    start = 1'b0;
    chk("R10 one done per run", n_done - d0, 1);
    repeat (4) @(negedge clk);
  endtask

  localparam logic [47:0] CR4 = 48'h0000_0000_1111;
  localparam logic [47:0] EQ4 = 48'h0000_0001_7777;

  task automatic t_reset();
    chk("R10 reset req", aux_req, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset pattern", pattern, 0);
  endtask

  task automatic t_basic();
    fill(CR4, EQ4); err_st = 0;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    chk("R8 pass", last_pass, 1);
    chk("R1 first pattern", pat_log[0], 1);
    chk("R7 eq pattern 2", pat_log[1], 2);
    chk("R10 end pattern", pat_log[2], 0);
    chk("R10 pattern at done", pat_at_done, 0);
    chk("R7 no commit on first eq pass", n_cfg_wr, 1);
    chk("R2 cr reads", n_cr_rd, 1);
    chk("R4 no pc2 traffic w/o pattern 3", n_pc2_wr + n_pc2_rd, 0);
    chk_rng("R9 cr wait", gap_cr, CRW, CRW + 4);
    chk_rng("R9 eq wait", gap_eq, EQW, EQW + 4);
  endtask

  task automatic t_intv();
    fill(CR4, EQ4); err_st = 0;
    run(3'd4, 1'b0, 8'd2, 1'b0);
    chk_rng("R9 interval cr wait", gap_cr, 8 * MS, 8 * MS + 4);
    chk_rng("R9 interval eq wait", gap_eq, 8 * MS, 8 * MS + 4);
  endtask

  task automatic t_cr_timeout();
    fill(48'h0, EQ4); err_st = 0;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    chk("R6 fail", last_pass, 0);
    chk("R6 five reads", n_cr_rd, 5);
    chk("R6 no eq", n_eq_rd, 0);
    chk("R10 end pattern after fail", pat_log[1], 0);
  endtask

  task automatic t_swing_restart();
    fill(48'h0001_0000_0000, EQ4); err_st = 0;
    for (int i = 0; i < 3; i++) cr_resp[i] = 48'h0;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    chk("R6 restart reads", n_cr_rd, 9);
    chk("R6 restart fail", last_pass, 0);
  endtask

  task automatic t_abort();
    fill(48'h0003_0000_0000, EQ4); err_st = 0;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    chk("R5 abort reads", n_cr_rd, 2);
    chk("R5 abort fail", last_pass, 0);
    chk("R5 max flag in config", last_cfg[7:0], 8'h07);
  endtask

  task automatic t_drive();
    fill(CR4, EQ4); err_st = 0;
    cr_resp[0] = 48'h0C61_0000_0000;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    chk("R3 config bytes", last_cfg, 32'h0038_0E01);
    chk("R3 swing out", swing, 8'h09);
    chk("R3 pre out", pre, 8'h34);
    chk("R2 pass after adjust", last_pass, 1);
  endtask

  task automatic t_one_lane();
    fill(48'h0000_0000_0001, 48'h0000_0001_0007); err_st = 0;
    run(3'd1, 1'b0, 8'd0, 1'b0);
    chk("R2 one lane pass", last_pass, 1);
    chk("R8 one lane reads", n_eq_rd, 1);
  endtask

  task automatic t_eq_fail();
    fill(CR4, 48'h0000_0001_1111); err_st = 0; pc2_resp = 8'h00;
    run(3'd4, 1'b1, 8'd0, 1'b0);
    chk("R8 six eq reads", n_eq_rd, 6);
    chk("R8 eq fail", last_pass, 0);
    chk("R7 pattern 3", pat_log[1], 3);
    chk("R7 config writes", n_cfg_wr, 6);
    chk("R4 pc2 writes", n_pc2_wr, 5);
    chk("R4 pc2 reads", n_pc2_rd, 6);
  endtask

  task automatic t_pc2();
    fill(CR4, EQ4); err_st = 0; pc2_resp = 8'hC9;
    eq_resp[0] = 48'h0000_0001_1111;
    run(3'd4, 1'b1, 8'd0, 1'b0);
    chk("R4 pc2 packing", last_pc2, 16'h7021);
    chk("R4 pc2 out", pc2, 8'hC9);
    chk("R8 pass on second pass", last_pass, 1);
  endtask

  task automatic t_cr_lost();
    fill(CR4, 48'h0); err_st = 0;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    chk("R8 cr lost reads", n_eq_rd, 1);
    chk("R8 cr lost fail", last_pass, 0);
  endtask

  task automatic t_err();
    fill(CR4, EQ4); err_st = 1;
    run(3'd4, 1'b0, 8'd0, 1'b0);
    err_st = 0;
    chk("R12 error fail", last_pass, 0);
    chk("R12 one read", n_cr_rd, 1);
    chk("R12 end pattern", pat_log[1], 0);
    chk("R12 pattern writes", n_tp, 2);
  endtask

  task automatic t_busy();
    int d0;
    fill(CR4, EQ4); err_st = 0;
    run(3'd4, 1'b0, 8'd0, 1'b1);
    d0 = n_done;
    repeat (200) @(negedge clk);
    chk("R11 no restart", n_done - d0, 0);
    chk("R11 pattern writes", n_tp, 3);
    chk("R11 pass unaffected", last_pass, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; lanes = 3'd4; tps3 = 1'b0; intv = 8'd0;
    err_st = 0; pc2_resp = 8'h00; hold_err = 0; n_done = 0; t_last = 0;
    fill(48'h0, 48'h0);
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_intv();
    t_cr_timeout();
    t_swing_restart();
    t_abort();
    t_drive();
    t_one_lane();
    t_eq_fail();
    t_pc2();
    t_cr_lost();
    t_err();
    t_busy();
    chk("R13 request held until done", hold_err, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule